// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one raw PWM level into a pair of complementary drive signals: a main output, which follows the raw level, and a complementary output, which follows its inverse. Between the falling edge of one output and the rising edge of the other it inserts a programmable non-overlap gap. That gap is counted in timer ticks, so each clock cycle with the tick strobe high counts once. Each direction has its own 8-bit gap count. One count sets the delay from main-fall to complementary-rise. The other sets the delay from complementary-fall to main-rise.

Each output has its own polarity inversion. The main output can also be forced to its inactive level, while the complementary output keeps running. The raw PWM level comes from a compare stage upstream. The prescaler that makes the tick, and the configuration bus, sit outside this block.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: While reset is asserted both outputs are 0. After reset, and before any tick, each output sits at its inactive level: 0 when its polarity bit is 0 and 1 when it is 1. Neither side is active.
- R2: The internal active levels change only on clock edges where `tick_en` is 1. With `tick_en` at 0 the active levels hold, whatever `pwm_raw` does.
- R3: On a tick where the main side is active and `pwm_raw` is 0, the main side goes inactive on that edge. The complementary side goes active `gap_lo` ticks later, provided `pwm_raw` stays 0.
- R4: On a tick where the complementary side is active and `pwm_raw` is 1, the complementary side goes inactive on that edge. The main side goes active `gap_hi` ticks later, provided `pwm_raw` stays 1.
- R5: A gap count of 0 makes the other side go active on the same edge on which the first side falls.
- R6: If `pwm_raw` reverses while a gap is running, the pending rise is cancelled. A fresh gap starts for the new direction, using that direction's count from the tick that sees the reversal.
- R7: The main and complementary sides are never active at the same time, before polarity is applied.
- R8: Each output equals its active level XOR its polarity bit, where 1 means inverted. A polarity change shows on the output one clock later, tick or not.
- R9: With `main_off` at 1, `out_main` is driven to its inactive level (equal to `main_inv`) one clock later, and the complementary side keeps switching normally.
- R10: The first tick after reset picks a side straight from `pwm_raw` (1 gives main, 0 gives complementary), with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 1 | Raw PWM level, 1 requests the main side |
| tick_en | input | 1 | Count-clock tick strobe |
| gap_lo | input | GAP_W | Ticks from main fall to complementary rise |
| gap_hi | input | GAP_W | Ticks from complementary fall to main rise |
| main_inv | input | 1 | Polarity of main output, 1 = inverted |
| comp_inv | input | 1 | Polarity of complementary output, 1 = inverted |
| main_off | input | 1 | 1 forces main output to its inactive level |
| out_main | output | 1 | Main drive output (registered) |
| out_comp | output | 1 | Complementary drive output (registered) |

## Verification
The output checks assume that the polarity and disable inputs are synchronous to `clk`. Each check takes the value these inputs had one clock earlier to work back to the active level. The bench changes every input only at the falling clock edge, and it changes the gap counts only while no gap is running, except in the cancel scenario. There the new count is set up before the reversal tick. Ticks come one cycle at a time, with idle cycles in between, so the tests can show that nothing moves without a tick.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_MAIN_ON     = 3'd1,
        ST_GAP_TO_COMP = 3'd2,
        ST_COMP_ON     = 3'd3,
        ST_GAP_TO_MAIN = 3'd4
    } dtg_state_e;

    // Registered level of one output pin from its active level and controls.
    function automatic logic pin_level(input logic active, input logic inv, input logic off);
        return off ? inv : (active ^ inv);
    endfunction

endpackage

// File: rtl/dtg_gap_fsm.sv
module dtg_gap_fsm #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pwm_raw,
    input  logic [GAP_W-1:0] gap_lo,
    input  logic [GAP_W-1:0] gap_hi,
    output logic             main_act_d,
    output logic             comp_act_d,
    output logic             main_act_q,
    output logic             comp_act_q
);
    import dtg_pkg::*;

    localparam logic [GAP_W-1:0] CNT_ZERO = '0;
    localparam logic [GAP_W-1:0] CNT_ONE  = {{(GAP_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        dtg_state_e       state;
        logic [GAP_W-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    // Start a gap toward one side; a zero count goes straight to the on state.
    function automatic fsm_t enter_gap(input logic to_main, input logic [GAP_W-1:0] len);
        fsm_t r;
        r.cnt = len;
        if (len == CNT_ZERO)
            r.state = to_main ? ST_MAIN_ON : ST_COMP_ON;
        else
            r.state = to_main ? ST_GAP_TO_MAIN : ST_GAP_TO_COMP;
        return r;
    endfunction

    always_comb begin
        nxt_d = cur_q;
        if (tick_en) begin
            unique case (cur_q.state)
                ST_IDLE: begin
                    nxt_d.state = pwm_raw ? ST_MAIN_ON : ST_COMP_ON;
                end
                ST_MAIN_ON: begin
                    if (!pwm_raw)
                        nxt_d = enter_gap(1'b0, gap_lo);
                end
                ST_GAP_TO_COMP: begin
                    if (pwm_raw)
                        nxt_d = enter_gap(1'b1, gap_hi);
                    else if (cur_q.cnt <= CNT_ONE)
                        nxt_d.state = ST_COMP_ON;
                    else
                        nxt_d.cnt = cur_q.cnt - CNT_ONE;
                end
                ST_COMP_ON: begin
                    if (pwm_raw)
                        nxt_d = enter_gap(1'b1, gap_hi);
                end
                ST_GAP_TO_MAIN: begin
                    if (!pwm_raw)
                        nxt_d = enter_gap(1'b0, gap_lo);
                    else if (cur_q.cnt <= CNT_ONE)
                        nxt_d.state = ST_MAIN_ON;
                    else
                        nxt_d.cnt = cur_q.cnt - CNT_ONE;
                end
                default: begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = CNT_ZERO;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= CNT_ZERO;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign main_act_d = (nxt_d.state == ST_MAIN_ON);
    assign comp_act_d = (nxt_d.state == ST_COMP_ON);
    assign main_act_q = (cur_q.state == ST_MAIN_ON);
    assign comp_act_q = (cur_q.state == ST_COMP_ON);

endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic act_d,
    input  logic inv,
    input  logic off,
    output logic pin_q
);
    import dtg_pkg::*;

    logic pin_d;

    always_comb begin
        pin_d = pin_level(act_d, inv, off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_raw,
    input  logic             tick_en,
    input  logic [GAP_W-1:0] gap_lo,
    input  logic [GAP_W-1:0] gap_hi,
    input  logic             main_inv,
    input  logic             comp_inv,
    input  logic             main_off,
    output logic             out_main,
    output logic             out_comp
);
    localparam int N_PINS = 2;

    logic main_act_d, comp_act_d;
    logic main_act_q, comp_act_q;

    logic [N_PINS-1:0] act_vec, inv_vec, off_vec, pin_vec;

    dtg_gap_fsm #(.GAP_W(GAP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .pwm_raw    (pwm_raw),
        .gap_lo     (gap_lo),
        .gap_hi     (gap_hi),
        .main_act_d (main_act_d),
        .comp_act_d (comp_act_d),
        .main_act_q (main_act_q),
        .comp_act_q (comp_act_q)
    );

    assign act_vec = {comp_act_d, main_act_d};
    assign inv_vec = {comp_inv, main_inv};
    assign off_vec = {1'b0, main_off};

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        dtg_out_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .act_d (act_vec[g]),
            .inv   (inv_vec[g]),
            .off   (off_vec[g]),
            .pin_q (pin_vec[g])
        );
    end

    assign out_main = pin_vec[0];
    assign out_comp = pin_vec[1];

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_raw,
    input logic             tick_en,
    input logic [GAP_W-1:0] gap_lo,
    input logic             main_inv,
    input logic             comp_inv,
    input logic             main_off,
    input logic             out_main,
    input logic             out_comp,
    input logic             main_act_q,
    input logic             comp_act_q
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R7
    overlap_free_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !(((out_main ^ $past(main_inv)) && !$past(main_off)) && (out_comp ^ $past(comp_inv))));

    // R9
    main_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(main_off) |-> (out_main == $past(main_inv)));

    // R2
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(main_act_q) && $stable(comp_act_q)));

    // R3
    main_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && main_act_q && !pwm_raw) |=> !main_act_q);

    // R5
    zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && main_act_q && !pwm_raw && gap_lo == '0) |=> comp_act_q);

    // R8
    comp_pol_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        out_comp == (comp_act_q ^ $past(comp_inv)));

endmodule

bind pwm_deadtime_gen dtg_chk #(.GAP_W(GAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_raw    (pwm_raw),
    .tick_en    (tick_en),
    .gap_lo     (gap_lo),
    .main_inv   (main_inv),
    .comp_inv   (comp_inv),
    .main_off   (main_off),
    .out_main   (out_main),
    .out_comp   (out_comp),
    .main_act_q (main_act_q),
    .comp_act_q (comp_act_q)
);

// File: tb/test_pwm_deadtime_gen.sv
module test_pwm_deadtime_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_raw = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] gap_lo = 8'd0;
    logic [7:0] gap_hi = 8'd0;
    logic       main_inv = 1'b0;
    logic       comp_inv = 1'b0;
    logic       main_off = 1'b0;
    logic       out_main, out_comp;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwm_deadtime_gen #(.GAP_W(8)) i_pwm_deadtime_gen (
        .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .tick_en(tick_en),
        .gap_lo(gap_lo), .gap_hi(gap_hi), .main_inv(main_inv),
        .comp_inv(comp_inv), .main_off(main_off),
        .out_main(out_main), .out_comp(out_comp)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One clock with the given tick value; outputs are sampled at the next falling edge.
    task automatic step(input logic t);
        tick_en = t;
        @(negedge clk);
        tick_en = 1'b0;
        // R7: never both active before polarity
        check("R7 overlap", (!main_off && (out_main ^ main_inv)) && (out_comp ^ comp_inv), 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset main", out_main, 1'b0);
        check("R1 reset comp", out_comp, 1'b0);
        rst_n = 1'b1;
        step(1'b0);
        step(1'b0);
        check("R1 idle main", out_main, 1'b0);
        check("R2 idle comp no tick", out_comp, 1'b0);
    endtask

    task automatic t_first_tick();
        pwm_raw = 1'b1;
        step(1'b1);
        check("R10 first tick main", out_main, 1'b1);
        check("R10 first tick comp", out_comp, 1'b0);
    endtask

    task automatic t_gap_lo();
        gap_lo = 8'd3;
        pwm_raw = 1'b0;
        step(1'b0);
        check("R2 no fall without tick", out_main, 1'b1);
        step(1'b1);
        check("R3 main falls", out_main, 1'b0);
        check("R3 comp waits t0", out_comp, 1'b0);
        step(1'b1);
        step(1'b0);
        step(1'b0);
        check("R2 gap held", out_comp, 1'b0);
        step(1'b1);
        check("R3 comp waits t2", out_comp, 1'b0);
        step(1'b1);
        check("R3 comp rises at gap_lo", out_comp, 1'b1);
    endtask

    task automatic t_gap_hi();
        gap_hi = 8'd2;
        pwm_raw = 1'b1;
        step(1'b1);
        check("R4 comp falls", out_comp, 1'b0);
        check("R4 main waits t0", out_main, 1'b0);
        step(1'b1);
        check("R4 main waits t1", out_main, 1'b0);
        step(1'b1);
        check("R4 main rises at gap_hi", out_main, 1'b1);
    endtask

    task automatic t_zero_gap();
        gap_lo = 8'd0;
        gap_hi = 8'd0;
        pwm_raw = 1'b0;
        step(1'b1);
        check("R5 lo zero main", out_main, 1'b0);
        check("R5 lo zero comp", out_comp, 1'b1);
        pwm_raw = 1'b1;
        step(1'b1);
        check("R5 hi zero comp", out_comp, 1'b0);
        check("R5 hi zero main", out_main, 1'b1);
    endtask

    task automatic t_cancel();
        gap_lo = 8'd4;
        gap_hi = 8'd2;
        pwm_raw = 1'b0;
        step(1'b1);
        check("R6 fall before cancel", out_main, 1'b0);
        step(1'b1);
        pwm_raw = 1'b1;
        step(1'b1);
        check("R6 cancel main off", out_main, 1'b0);
        check("R6 cancel comp off", out_comp, 1'b0);
        step(1'b1);
        check("R6 restart waiting", out_main, 1'b0);
        step(1'b1);
        check("R6 main after new gap", out_main, 1'b1);
        check("R6 comp never rose", out_comp, 1'b0);
    endtask

    task automatic t_polarity();
        main_inv = 1'b1;
        comp_inv = 1'b1;
        step(1'b0);
        check("R8 main inverted", out_main, 1'b0);
        check("R8 comp inverted", out_comp, 1'b1);
        main_inv = 1'b0;
        comp_inv = 1'b0;
        step(1'b0);
        check("R8 main normal", out_main, 1'b1);
        check("R8 comp normal", out_comp, 1'b0);
    endtask

    task automatic t_disable();
        main_off = 1'b1;
        main_inv = 1'b1;
        comp_inv = 1'b1;
        step(1'b0);
        check("R9 off inverted idle", out_main, 1'b1);
        main_inv = 1'b0;
        step(1'b0);
        check("R9 off normal idle", out_main, 1'b0);
        gap_lo = 8'd0;
        pwm_raw = 1'b0;
        step(1'b1);
        check("R9 comp active inverted", out_comp, 1'b0);
        check("R9 main still off", out_main, 1'b0);
        comp_inv = 1'b0;
        step(1'b0);
        check("R9 comp active normal", out_comp, 1'b1);
        main_off = 1'b0;
        step(1'b0);
        check("R9 main released inactive", out_main, 1'b0);
    endtask

    initial begin
        t_reset();
        t_first_tick();
        t_gap_lo();
        t_gap_hi();
        t_zero_gap();
        t_cancel();
        t_polarity();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule